// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Synchronous Rectification

This block is the per-bridge switch controller of a DC motor driver. It takes the drive direction, an external enable pin with a programmable polarity, and an internal off-time request from a fixed-off-time current regulator. It also takes two current-sense flags: zero load current, and reversed current at the trip limit. From these it produces the four gate enables of a full bridge. Those are the high-side and low-side switch of leg A, and the high-side and low-side switch of leg B.

During an off period the block decides which switches are chopped and which carry the recirculating current. A 2-bit mode sets synchronous rectification. A programmable crossover count delays every switch that turns on, so the two switches of one leg never conduct together. A fault or idle input clears all four gates at once, without waiting for a clock edge.

The block has no data stream, so every pin is a plain level signal sampled on the system clock. Analog sensing and the gate drivers themselves are outside this block.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: Outside an off period, `dir_fwd`=1 turns on the A high-side and B low-side switches, and `dir_fwd`=0 turns on the B high-side and A low-side switches. Every other gate is off.
- R2: An off period is in force when `en_pin` equals `en_pol` (an enable chop) or when `int_off` is 1. The decay of an enable chop is slow when `ext_slow`=1 and fast when `ext_slow`=0. Without an enable chop, the decay is fast when `int_fast`=1 and slow when `int_fast`=0. When both sources request off, the enable chop decides the decay.
- R3: Slow decay with `sr_mode` 00, 10 or 11: the driving high-side switch turns off and the far leg's low-side switch stays on. The driving leg's low-side switch turns on when rectification is allowed.
- R4: Fast decay with `sr_mode` 00, 10 or 11: both driving switches turn off. The driving leg's low-side switch and the far leg's high-side switch turn on when rectification is allowed.
- R5: With `sr_mode`=01 (low side only), the low-side switch is the one chopped and no high-side switch ever rectifies. In slow decay only the driving high-side switch stays on. In fast decay only the driving leg's low-side switch is on.
- R6: `sr_mode`=00 never turns on a rectifying switch. Slow decay leaves only the far low-side switch on, and fast decay leaves all gates off.
- R7: With `sr_mode`=10, a 1 on `zero_i` during an off period stops rectification. The stop holds until that off period ends.
- R8: With `sr_mode`=11, `zero_i` has no effect. A 1 on `rev_lim` during an off period stops rectification until that off period ends.
- R9: When the wanted gate set changes, a removed switch goes off after one clock. A newly wanted switch goes on `dead_cnt`+1 clocks after the first edge that sees the change.
- R10: The high-side and low-side switch of one leg are never on together. A switch only turns on if its leg partner was off in the previous cycle.
- R11: `fault` or `idle` forces all gates off in the same cycle. After release, the gates come back only through the R9 delay.
- R12: During and right after reset all gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_fwd | input | 1 | Drive direction, 1 = forward |
| en_pin | input | 1 | External enable level |
| en_pol | input | 1 | Enable polarity; chop when equal to `en_pin` |
| ext_slow | input | 1 | Decay for enable chop, 1 = slow |
| int_off | input | 1 | Internal off-time request |
| int_fast | input | 1 | Internal off in fast-decay portion |
| sr_mode | input | 2 | Rectification mode: 00 none, 01 low side only, 10 active, 11 passive |
| zero_i | input | 1 | Zero load current detected |
| rev_lim | input | 1 | Reversed current reached trip limit |
| dead_cnt | input | CW | Crossover delay in clocks |
| fault | input | 1 | Fault, clears all gates |
| idle | input | 1 | Idle, clears all gates |
| gate_ah | output | 1 | Leg A high-side enable |
| gate_al | output | 1 | Leg A low-side enable |
| gate_bh | output | 1 | Leg B high-side enable |
| gate_bl | output | 1 | Leg B low-side enable |

## Verification
A wrong gate-selection decode shows up at the gates within `dead_cnt`+1 clocks of any input change. The bench therefore sweeps every combination of direction, enable, polarity, decay, off request and mode, and compares the settled pattern. A faulty crossover counter shows as a gate that rises one or more clocks early or late, so the bench samples each cycle across a transition.

A lost cutoff flag shows as a rectifier that comes back within a few clocks after the flag pulse drops. The bench holds the off period and watches for this. A fault path that passes through a register would leave a gate high for one half cycle, so the bench looks within the same cycle that `fault` or `idle` rises.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    SR_NONE    = 2'b00,
    SR_LOWONLY = 2'b01,
    SR_ACTIVE  = 2'b10,
    SR_PASSIVE = 2'b11
  } sr_mode_e;

  localparam int NGATE  = 4;
  localparam int IDX_AH = 3;
  localparam int IDX_AL = 2;
  localparam int IDX_BH = 1;
  localparam int IDX_BL = 0;
endpackage

// File: rtl/hb_sr_gate.sv
module hb_sr_gate
  import hb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     off,
  input  sr_mode_e mode,
  input  logic     zero_i,
  input  logic     rev_lim,
  output logic     sr_ok
);
  logic cut_q;
  logic cut_now;

  always_comb begin
    cut_now = ((mode == SR_ACTIVE) && zero_i) || ((mode == SR_PASSIVE) && rev_lim);
    sr_ok   = (mode != SR_NONE) && !cut_q && !cut_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cut_q <= 1'b0;
    else if (off) cut_q <= cut_q | cut_now;
    else          cut_q <= 1'b0;
  end

  // R7 R8
  sticky_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !sr_ok && (mode inside {SR_ACTIVE, SR_PASSIVE}))
      |=> (!off || !sr_ok || !$stable(mode)));
endmodule

// File: rtl/hb_pattern.sv
module hb_pattern
  import hb_pkg::*;
(
  input  logic             dir_fwd,
  input  logic             en_pin,
  input  logic             en_pol,
  input  logic             ext_slow,
  input  logic             int_off,
  input  logic             int_fast,
  input  sr_mode_e         mode,
  input  logic             sr_ok,
  output logic             off,
  output logic [NGATE-1:0] tgt
);
  logic chop, slow;
  logic src_hi, src_lo, far_hi, far_lo;

  always_comb begin
    chop = (en_pin == en_pol);
    off  = chop || int_off;
    slow = chop ? ext_slow : !int_fast;
    src_hi = 1'b0;
    src_lo = 1'b0;
    far_hi = 1'b0;
    far_lo = 1'b0;
    if (!off) begin
      src_hi = 1'b1;
      far_lo = 1'b1;
    end else if (mode == SR_LOWONLY) begin
      if (slow) src_hi = 1'b1;
      else      src_lo = sr_ok;
    end else if (slow) begin
      far_lo = 1'b1;
      src_lo = sr_ok;
    end else begin
      src_lo = sr_ok;
      far_hi = sr_ok;
    end
    tgt = '0;
    if (dir_fwd) begin
      tgt[IDX_AH] = src_hi;
      tgt[IDX_AL] = src_lo;
      tgt[IDX_BH] = far_hi;
      tgt[IDX_BL] = far_lo;
    end else begin
      tgt[IDX_BH] = src_hi;
      tgt[IDX_BL] = src_lo;
      tgt[IDX_AH] = far_hi;
      tgt[IDX_AL] = far_lo;
    end
  end
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic [NGATE-1:0] tgt,
  input  logic [CW-1:0]    dead_cnt,
  output logic [NGATE-1:0] g
);
  logic [NGATE-1:0] tgt_q;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g     <= '0;
      tgt_q <= '0;
      cnt   <= '0;
    end else if (kill) begin
      g     <= '0;
      tgt_q <= '0;
      cnt   <= '0;
    end else if (tgt != tgt_q) begin
      tgt_q <= tgt;
      cnt   <= dead_cnt;
      g     <= g & tgt;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      g <= (cnt == '0) ? tgt : (g & tgt);
    end
  end

  // R10
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(g[IDX_AH] && g[IDX_AL]) && !(g[IDX_BH] && g[IDX_BL]));

  for (genvar i = 0; i < NGATE; i++) begin : g_gap
    // R9 R10
    gap_before_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g[i]) |-> !$past(g[i ^ 1]));
  end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_fwd,
  input  logic          en_pin,
  input  logic          en_pol,
  input  logic          ext_slow,
  input  logic          int_off,
  input  logic          int_fast,
  input  logic [1:0]    sr_mode,
  input  logic          zero_i,
  input  logic          rev_lim,
  input  logic [CW-1:0] dead_cnt,
  input  logic          fault,
  input  logic          idle,
  output logic          gate_ah,
  output logic          gate_al,
  output logic          gate_bh,
  output logic          gate_bl
);
  sr_mode_e         mode;
  logic             off, sr_ok, kill;
  logic [NGATE-1:0] tgt, g;

  assign mode = sr_mode_e'(sr_mode);
  assign kill = fault | idle;

  hb_sr_gate u_sr (
    .clk(clk), .rst_n(rst_n), .off(off), .mode(mode),
    .zero_i(zero_i), .rev_lim(rev_lim), .sr_ok(sr_ok)
  );

  hb_pattern u_pat (
    .dir_fwd(dir_fwd), .en_pin(en_pin), .en_pol(en_pol),
    .ext_slow(ext_slow), .int_off(int_off), .int_fast(int_fast),
    .mode(mode), .sr_ok(sr_ok), .off(off), .tgt(tgt)
  );

  hb_deadtime #(.CW(CW)) u_dt (
    .clk(clk), .rst_n(rst_n), .kill(kill), .tgt(tgt),
    .dead_cnt(dead_cnt), .g(g)
  );

  assign gate_ah = g[IDX_AH] & ~kill;
  assign gate_al = g[IDX_AL] & ~kill;
  assign gate_bh = g[IDX_BH] & ~kill;
  assign gate_bl = g[IDX_BL] & ~kill;

  // R11
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(gate_ah || gate_al || gate_bh || gate_bl));
endmodule

// File: tb/hbridge_gate_ctrl_tb.sv
module hbridge_gate_ctrl_tb;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_fwd = 1'b1, en_pin = 1'b0, en_pol = 1'b1, ext_slow = 1'b0;
  logic int_off = 1'b0, int_fast = 1'b0, zero_i = 1'b0, rev_lim = 1'b0;
  logic fault = 1'b0, idle = 1'b0;
  logic [1:0] sr_mode = 2'b10;
  logic [CW-1:0] dead_cnt = 8'd3;
  logic gate_ah, gate_al, gate_bh, gate_bl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbridge_gate_ctrl #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .en_pin(en_pin),
    .en_pol(en_pol), .ext_slow(ext_slow), .int_off(int_off),
    .int_fast(int_fast), .sr_mode(sr_mode), .zero_i(zero_i),
    .rev_lim(rev_lim), .dead_cnt(dead_cnt), .fault(fault), .idle(idle),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {gate_ah, gate_al, gate_bh, gate_bl};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gates(ah al bh bl) act=%b exp=%b", req, act, exp);
    end
  endtask

  // expected settled gates {ah,al,bh,bl}, rectification allowed = sr
  function automatic logic [3:0] expect_g(logic d, logic pin, logic pol,
      logic es, logic io, logic ifa, logic [1:0] m, logic sr);
    logic o, s, shi, slo, fhi, flo;
    o = (pin == pol) || io;
    s = (pin == pol) ? es : !ifa;
    shi = 0; slo = 0; fhi = 0; flo = 0;
    if (!o) begin shi = 1; flo = 1; end
    else if (m == 2'b01) begin if (s) shi = 1; else slo = 1; end
    else if (s) begin flo = 1; slo = sr; end
    else begin slo = sr; fhi = sr; end
    return d ? {shi, slo, fhi, flo} : {fhi, flo, shi, slo};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R12 reset", 4'b0000);
    rst_n = 1'b1;
    step(1);
    chk("R12 after reset", 4'b0000);

    // exhaustive decode sweep: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 256; v++) begin
      string tag;
      logic o, s;
      {dir_fwd, en_pin, en_pol, ext_slow, int_off, int_fast, sr_mode} = v[7:0];
      step(8);
      o = (en_pin == en_pol) || int_off;
      s = (en_pin == en_pol) ? ext_slow : !int_fast;
      if (!o) tag = "R1 drive";
      else if (sr_mode == 2'b00) tag = "R2 R6 none";
      else if (sr_mode == 2'b01) tag = "R2 R5 lowonly";
      else if (s) tag = "R2 R3 slow";
      else tag = "R2 R4 fast";
      chk(tag, expect_g(dir_fwd, en_pin, en_pol, ext_slow, int_off,
                        int_fast, sr_mode, sr_mode != 2'b00));
    end

    // dead time, D=3: forward drive -> internal slow off, active mode
    dead_cnt = 8'd3; sr_mode = 2'b10; dir_fwd = 1; en_pol = 1; en_pin = 0;
    int_off = 0; int_fast = 0;
    step(8);
    chk("R1 fwd steady", 4'b1001);
    int_off = 1;
    step(1); chk("R9 removed off after one clock", 4'b0001);
    step(3); chk("R9 new still off at D", 4'b0001);
    step(1); chk("R9 new on at D+1", 4'b0101);

    // R7 active: zero current cuts rectifier, sticky
    zero_i = 1; step(1); zero_i = 0;
    step(1); chk("R7 zero cut", 4'b0001);
    step(6); chk("R7 cut sticky", 4'b0001);
    int_off = 0; step(8);
    int_off = 1; step(8);
    chk("R7 cut cleared by new off", 4'b0101);

    // R8 passive: zero ignored, reverse limit cuts
    sr_mode = 2'b11; step(8);
    zero_i = 1; step(1); zero_i = 0; step(6);
    chk("R8 zero ignored", 4'b0101);
    rev_lim = 1; step(1); rev_lim = 0;
    step(6); chk("R8 rev limit cut sticky", 4'b0001);

    // R9 with D=0
    dead_cnt = 8'd0; int_off = 0;
    step(1); chk("R9 D0 removed", 4'b0001);
    step(1); chk("R9 D0 on next clock", 4'b1001);

    // R11 fault and idle
    dead_cnt = 8'd3; step(4);
    fault = 1; #1; chk("R11 fault same cycle", 4'b0000);
    step(2); chk("R11 fault held", 4'b0000);
    fault = 0;
    step(4); chk("R11 restart waits", 4'b0000);
    step(1); chk("R11 restart done", 4'b1001);
    idle = 1; #1; chk("R11 idle same cycle", 4'b0000);
    step(1); idle = 0; step(8);
    chk("R11 after idle", 4'b1001);

    // R10 reversal: fwd -> rev via a settled check
    dir_fwd = 0; step(1); chk("R10 all removed first", 4'b0000);
    step(4); chk("R10 R1 rev drive", 4'b0110);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule